// File: doc/BRIEF.md
# Parallel Display Bus Cycle Engine

This block produces single read and write cycles on an 8080-style parallel bus that connects to a display panel with its own frame memory. Each cycle drives an active-low chip select and an active-low write or read strobe. It also drives a command/data select line. The start and end tick of every strobe, and the length of the cycle, come from two packed timing words. A tick is one clock long, or two clocks long when the divider bit is set.

Requests enter on a valid/ready channel that carries a kind and a data word. There are three kinds: a command write, a parameter write, and a single read. `req_ready` is low while a cycle runs and while a read result waits for its consumer. A requester holds `req_valid`, `req_kind` and `req_data` steady until the handshake. The block samples the configuration inputs only in the handshake cycle, so they may change once a cycle has been launched.

A read result leaves on a valid/ready channel. `rsp_valid` rises in the first clock after the read cycle ends. `rsp_valid` and `rsp_data` then hold until `rsp_ready` is seen high.

Top module: `pbus_engine`

## Requirements
- R1: After reset, all three strobes are high, `bus_dc` is high, `bus_oe` is low, `busy` is low, `rsp_valid` is low and `req_ready` is high.
- R2: Ticks are numbered from 0 in the first clock after the handshake. Chip select is low during ticks t with cs_on <= t < cs_off, where cs_on is `cfg_onoff[3:0]` and cs_off is `cfg_onoff[9:4]`.
- R3: For write kinds, the write strobe is low during ticks t with we_on <= t < we_off, where we_on is `cfg_onoff[13:10]` and we_off is `cfg_onoff[19:14]`. The read strobe stays high.
- R4: For reads, the read strobe is low during ticks t with re_on <= t < re_off, where re_on is `cfg_onoff[23:20]` and re_off is `cfg_onoff[29:24]`. The write strobe stays high and `bus_oe` stays low.
- R5: A write cycle lasts `cfg_cycle[5:0]` ticks and a read cycle lasts `cfg_cycle[11:6]` ticks. A length of 0 is taken as 1 tick. `busy` is high for exactly the length of the cycle. In the clock after the cycle, the bus is idle: all strobes are high, `bus_dc` is high and `bus_oe` is low.
- R6: When `cfg_div2` is 1, every tick lasts two clocks, which doubles every window and the cycle length. When it is 0, a tick lasts one clock.
- R7: `req_kind` encodes the cycle kind: 0 is a command write, 1 is a parameter write, 2 is a read, and 3 is a parameter write. A command drives `bus_dc` low for the whole cycle. Parameter and read cycles drive it high. Write cycles drive `bus_oe` high and hold `bus_dout` steady for the whole cycle.
- R8: A `cfg_width` of 3 selects 16 bits per cycle. Any other value (0 is the normal 8-bit code) selects 8 bits. In 8-bit mode, write data and read results carry only the low byte, and the upper byte is zero.
- R9: A read samples `bus_din` in the first clock of the access tick `cfg_cycle[27:22]`. If that tick is at or past the end of the cycle, the sample is taken in the first clock of the last tick. The result appears on `rsp_data` with `rsp_valid` in the clock after the cycle ends, and both hold until `rsp_ready` is high.
- R10: `req_ready` is low while `busy` or `rsp_valid` is high. A request offered at that time is held and is launched at the first edge after both have dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_kind | input | 2 | 0 command, 1 parameter, 2 read, 3 parameter |
| req_data | input | DATA_W | Word to place on the bus for writes |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | DATA_W | Captured read word |
| cfg_onoff | input | 32 | Strobe on/off tick word |
| cfg_cycle | input | 32 | Cycle length and access tick word |
| cfg_div2 | input | 1 | Tick of two clocks when set |
| cfg_width | input | 2 | 3 for 16-bit cycles, otherwise 8-bit |
| busy | output | 1 | Bus cycle in progress |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | Low for command, high for data |
| bus_oe | output | 1 | Data bus drive enable |
| bus_dout | output | DATA_W | Data driven to the panel |
| bus_din | input | DATA_W | Data returned by the panel |

## Verification
For a cycle of L ticks and D clocks per tick, the handshake edge is followed by L·D clocks with `busy` high. The bench compares every strobe, the select line and the bus data in each of those clocks at the falling edge, using the tick index k/D for clock k. One clock later it expects an idle bus. For a read, the bench also expects the result in that same clock: the word the bench drove during clock min(access, L−1)·D. The bench changes `bus_din` every clock, so sampling one clock too early or too late gives a wrong word. When the consumer stalls, the bench holds `rsp_ready` low for three clocks and checks that the word and the request back-pressure both hold.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int TICK_W = 6;
  localparam int EDGE_W = 4;
  localparam logic [1:0] WIDE_CODE = 2'd3;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_PARAM = 2'd1,
    KIND_READ  = 2'd2,
    KIND_ALT   = 2'd3
  } kind_e;

  // Bit layout of the on/off word, most significant field first.
  typedef struct packed {
    logic [1:0]        spare;
    logic [TICK_W-1:0] re_off;
    logic [EDGE_W-1:0] re_on;
    logic [TICK_W-1:0] we_off;
    logic [EDGE_W-1:0] we_on;
    logic [TICK_W-1:0] cs_off;
    logic [EDGE_W-1:0] cs_on;
  } onoff_word_t;

  // Bit layout of the cycle word, most significant field first.
  typedef struct packed {
    logic [3:0]        spare_hi;
    logic [TICK_W-1:0] access;
    logic [3:0]        spare_mid;
    logic [TICK_W-1:0] cs_width;
    logic [TICK_W-1:0] rd_len;
    logic [TICK_W-1:0] wr_len;
  } cycle_word_t;

  localparam int N_WIN = 3;
  localparam int WIN_CS = 0;
  localparam int WIN_WE = 1;
  localparam int WIN_RE = 2;

endpackage

// File: rtl/pbus_ticker.sv
module pbus_ticker #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             div2,
  input  logic [CNT_W-1:0] len,
  output logic             active,
  output logic [CNT_W-1:0] tick,
  output logic             first,
  output logic             last
);

  logic [CNT_W-1:0] len_q;
  logic             div2_q;
  logic             half;

  assign first = active && !half;
  assign last  = active && (tick == len_q - CNT_W'(1)) && (!div2_q || half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tick   <= '0;
      half   <= 1'b0;
      len_q  <= CNT_W'(1);
      div2_q <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      tick   <= '0;
      half   <= 1'b0;
      len_q  <= (len == '0) ? CNT_W'(1) : len;
      div2_q <= div2;
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        tick   <= '0;
        half   <= 1'b0;
      end else if (div2_q && !half) begin
        half <= 1'b1;
      end else begin
        half <= 1'b0;
        tick <= tick + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/pbus_window.sv
module pbus_window #(
  parameter int CNT_W = 6
) (
  input  logic             active,
  input  logic             enable,
  input  logic [CNT_W-1:0] tick,
  input  logic [CNT_W-1:0] t_on,
  input  logic [CNT_W-1:0] t_off,
  output logic             strobe_n
);

  always_comb begin
    strobe_n = 1'b1;
    if (active && enable && (tick >= t_on) && (tick < t_off))
      strobe_n = 1'b0;
  end

endmodule

// File: rtl/pbus_capture.sv
module pbus_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              finish,
  input  logic [DATA_W-1:0] din,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic [DATA_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (sample)
        held <= din;
      if (finish) begin
        rsp_valid <= 1'b1;
        rsp_data  <= sample ? din : held;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pbus_engine.sv
module pbus_engine
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [31:0]       cfg_onoff,
  input  logic [31:0]       cfg_cycle,
  input  logic              cfg_div2,
  input  logic [1:0]        cfg_width,
  output logic              busy,
  output logic              bus_cs_n,
  output logic              bus_we_n,
  output logic              bus_re_n,
  output logic              bus_dc,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);

  localparam int NARROW_W = DATA_W / 2;

  onoff_word_t onoff_w;
  cycle_word_t cycle_w;
  assign onoff_w = onoff_word_t'(cfg_onoff);
  assign cycle_w = cycle_word_t'(cfg_cycle);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{onoff_w.spare, cycle_w.spare_hi, cycle_w.spare_mid, cycle_w.cs_width};

  // Launch-side decode of the live request and configuration.
  logic              launch;
  logic              launch_rd;
  logic [TICK_W-1:0] launch_len;
  logic [TICK_W-1:0] launch_len_eff;
  logic [TICK_W-1:0] launch_cap;
  logic              launch_wide;

  // Launch-time copies that shape the running cycle.
  kind_e             kind_q;
  logic              wide_q;
  logic [DATA_W-1:0] data_q;
  logic [TICK_W-1:0] cap_q;
  logic [TICK_W-1:0] on_q  [N_WIN];
  logic [TICK_W-1:0] off_q [N_WIN];

  logic              active;
  logic [TICK_W-1:0] tick;
  logic              first;
  logic              last;
  logic              rd_q;
  logic [N_WIN-1:0]  win_en;
  logic [N_WIN-1:0]  win_n;
  logic [DATA_W-1:0] din_fit;

  assign req_ready      = !active && !rsp_valid;
  assign launch         = req_valid && req_ready;
  assign launch_rd      = (kind_e'(req_kind) == KIND_READ);
  assign launch_len     = launch_rd ? cycle_w.rd_len : cycle_w.wr_len;
  assign launch_len_eff = (launch_len == '0) ? TICK_W'(1) : launch_len;
  assign launch_cap     = (cycle_w.access < launch_len_eff) ? cycle_w.access
                                                             : launch_len_eff - TICK_W'(1);
  assign launch_wide    = (cfg_width == WIDE_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_PARAM;
      wide_q <= 1'b0;
      data_q <= '0;
      cap_q  <= '0;
      for (int i = 0; i < N_WIN; i++) begin
        on_q[i]  <= '0;
        off_q[i] <= '0;
      end
    end else if (launch) begin
      kind_q <= kind_e'(req_kind);
      wide_q <= launch_wide;
      data_q <= launch_wide ? req_data : {{(DATA_W-NARROW_W){1'b0}}, req_data[NARROW_W-1:0]};
      cap_q  <= launch_cap;
      on_q[WIN_CS]  <= TICK_W'(onoff_w.cs_on);
      off_q[WIN_CS] <= onoff_w.cs_off;
      on_q[WIN_WE]  <= TICK_W'(onoff_w.we_on);
      off_q[WIN_WE] <= onoff_w.we_off;
      on_q[WIN_RE]  <= TICK_W'(onoff_w.re_on);
      off_q[WIN_RE] <= onoff_w.re_off;
    end
  end

  pbus_ticker #(.CNT_W(TICK_W)) u_ticker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (launch),
    .div2   (cfg_div2),
    .len    (launch_len),
    .active (active),
    .tick   (tick),
    .first  (first),
    .last   (last)
  );

  assign rd_q = (kind_q == KIND_READ);
  assign win_en[WIN_CS] = 1'b1;
  assign win_en[WIN_WE] = !rd_q;
  assign win_en[WIN_RE] = rd_q;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    pbus_window #(.CNT_W(TICK_W)) u_win (
      .active   (active),
      .enable   (win_en[w]),
      .tick     (tick),
      .t_on     (on_q[w]),
      .t_off    (off_q[w]),
      .strobe_n (win_n[w])
    );
  end

  assign bus_cs_n = win_n[WIN_CS];
  assign bus_we_n = win_n[WIN_WE];
  assign bus_re_n = win_n[WIN_RE];
  assign bus_dc   = !(active && (kind_q == KIND_CMD));
  assign bus_oe   = active && !rd_q;
  assign bus_dout = data_q;
  assign busy     = active;

  assign din_fit = wide_q ? bus_din : {{(DATA_W-NARROW_W){1'b0}}, bus_din[NARROW_W-1:0]};

  pbus_capture #(.DATA_W(DATA_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (active && rd_q && first && (tick == cap_q)),
    .finish    (last && rd_q),
    .din       (din_fit),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/pbus_engine_chk.sv
module pbus_engine_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              busy,
  input logic              bus_cs_n,
  input logic              bus_we_n,
  input logic              bus_re_n,
  input logic              bus_dc,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_dout
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_cs_n && bus_we_n && bus_re_n && bus_dc && !bus_oe)); // R5

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re_n |-> bus_we_n); // R4

  AST_READ_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> bus_re_n); // R4

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R10

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9

  AST_BUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bus_dout) && $stable(bus_dc))); // R7

endmodule

bind pbus_engine pbus_engine_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pbus_engine_test.sv
module pbus_engine_test;

  localparam int DW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_kind;
  logic [DW-1:0] req_data;
  logic          rsp_valid;
  logic          rsp_ready;
  logic [DW-1:0] rsp_data;
  logic [31:0]   cfg_onoff;
  logic [31:0]   cfg_cycle;
  logic          cfg_div2;
  logic [1:0]    cfg_width;
  logic          busy;
  logic          bus_cs_n;
  logic          bus_we_n;
  logic          bus_re_n;
  logic          bus_dc;
  logic          bus_oe;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din;

  pbus_engine #(.DATA_W(DW)) uut (.*);

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    int          kind;
    int          data;
    logic [31:0] onoff;
    logic [31:0] cyc;
    int          div2;
    int          width;
    int          base;
    bit          hold;
  } item_t;

  item_t q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_onoff(int cson, int csoff, int weon, int weoff, int reon, int reoff);
    return 32'((cson & 15) | ((csoff & 63) << 4) | ((weon & 15) << 10) |
               ((weoff & 63) << 14) | ((reon & 15) << 20) | ((reoff & 63) << 24));
  endfunction

  function automatic logic [31:0] mk_cyc(int wecyc, int recyc, int acc);
    return 32'((wecyc & 63) | ((recyc & 63) << 6) | ((acc & 63) << 22));
  endfunction

  function automatic int fit(int v, int width);
    return (width == 3) ? (v & 16'hFFFF) : (v & 8'hFF);
  endfunction

  function automatic item_t mk(int kind, int data, logic [31:0] onoff, logic [31:0] cyc,
                               int div2, int width, int base, bit hold);
    item_t it;
    it.kind = kind; it.data = data; it.onoff = onoff; it.cyc = cyc;
    it.div2 = div2; it.width = width; it.base = base; it.hold = hold;
    return it;
  endfunction

  // Driver: pushes the expected item, then offers the request until accepted.
  task automatic send(input item_t it);
    @(negedge clk);
    cfg_onoff = it.onoff;
    cfg_cycle = it.cyc;
    cfg_div2  = it.div2[0];
    cfg_width = it.width[1:0];
    req_kind  = it.kind[1:0];
    req_data  = it.data[DW-1:0];
    q.push_back(it);
    req_valid = 1'b1;
    forever begin
      if (req_ready) begin
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  // Monitor: called at the falling edge of the first busy clock.
  task automatic check_cycle(input item_t it);
    int d, len, cson, csoff, weon, weoff, reon, reoff, acc, cap, expd;
    bit rd;
    d     = it.div2 ? 2 : 1;
    rd    = (it.kind == 2);
    len   = rd ? ((it.cyc >> 6) & 63) : (it.cyc & 63);
    if (len == 0) len = 1;
    cson  = it.onoff & 15;
    csoff = (it.onoff >> 4) & 63;
    weon  = (it.onoff >> 10) & 15;
    weoff = (it.onoff >> 14) & 63;
    reon  = (it.onoff >> 20) & 15;
    reoff = (it.onoff >> 24) & 63;
    acc   = (it.cyc >> 22) & 63;
    cap   = (acc < len) ? acc : len - 1;
    expd  = fit(it.base + cap * d, it.width);
    if (it.hold) rsp_ready = 1'b0;
    for (int k = 0; k < len * d; k++) begin
      int t;
      if (k > 0) @(negedge clk);
      t = k / d;
      bus_din = DW'(it.base + k);
      chk(busy && !req_ready, "R10 busy with ready low", {busy, req_ready}, 2);
      chk(bus_cs_n == !(t >= cson && t < csoff), "R2 R6 chip select", bus_cs_n, !(t >= cson && t < csoff));
      chk(bus_we_n == (rd || !(t >= weon && t < weoff)), "R3 R6 write strobe", bus_we_n, (rd || !(t >= weon && t < weoff)));
      chk(bus_re_n == (!rd || !(t >= reon && t < reoff)), "R4 R6 read strobe", bus_re_n, (!rd || !(t >= reon && t < reoff)));
      chk(bus_dc == (it.kind != 0), "R7 command select", bus_dc, (it.kind != 0));
      if (!rd)
        chk(bus_oe && (int'(bus_dout) == fit(it.data, it.width)), "R8 write data", bus_dout, fit(it.data, it.width));
      else
        chk(!bus_oe, "R4 no drive on read", bus_oe, 0);
    end
    @(negedge clk);
    chk(!busy && bus_cs_n && bus_we_n && bus_re_n && bus_dc && !bus_oe,
        "R5 R6 idle after cycle", {busy, bus_cs_n, bus_we_n, bus_re_n, bus_dc, bus_oe}, 6'b011110);
    if (rd) begin
      chk(rsp_valid && (int'(rsp_data) == expd), "R9 R8 read result", rsp_data, expd);
      if (it.hold) begin
        repeat (3) begin
          @(negedge clk);
          chk(rsp_valid && (int'(rsp_data) == expd) && !req_ready, "R9 R10 result held", rsp_data, expd);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        chk(!rsp_valid, "R9 result released", rsp_valid, 0);
      end
    end
  endtask

  initial begin
    item_t it;
    rsp_ready = 1'b1;
    bus_din   = '0;
    forever begin
      @(negedge clk);
      if (rst_n && busy) begin
        if (q.size() == 0) begin
          chk(0, "R10 unexpected cycle", 1, 0);
        end else begin
          it = q.pop_front();
          check_cycle(it);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_kind = '0;
    req_data = '0;
    cfg_onoff = '0;
    cfg_cycle = '0;
    cfg_div2 = 1'b0;
    cfg_width = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_cs_n && bus_we_n && bus_re_n && bus_dc && !bus_oe, "R1 strobes idle",
        {bus_cs_n, bus_we_n, bus_re_n, bus_dc, bus_oe}, 5'b11110);
    chk(!busy && req_ready && !rsp_valid, "R1 handshake idle", {busy, req_ready, rsp_valid}, 3'b010);

    // Command write, 16-bit, one clock per tick
    send(mk(0, 16'hA55A, mk_onoff(1, 5, 2, 4, 0, 0), mk_cyc(6, 0, 0), 0, 3, 0, 0));
    // Parameter write, 8-bit, two clocks per tick
    send(mk(1, 16'h1234, mk_onoff(0, 3, 1, 3, 0, 0), mk_cyc(4, 0, 0), 1, 0, 0, 0));
    // Read, 16-bit, access inside the cycle
    send(mk(2, 0, mk_onoff(1, 6, 0, 0, 1, 5), mk_cyc(0, 6, 3), 0, 3, 16'h5100, 0));
    // Read, 8-bit, two clocks per tick
    send(mk(2, 0, mk_onoff(0, 4, 0, 0, 1, 3), mk_cyc(0, 4, 2), 1, 0, 16'h7A30, 0));
    // Read with access tick past the cycle end
    send(mk(2, 0, mk_onoff(0, 4, 0, 0, 0, 4), mk_cyc(0, 4, 9), 0, 3, 16'h2200, 0));
    // Zero length taken as one tick
    send(mk(1, 16'hBEEF, mk_onoff(0, 1, 0, 1, 0, 0), mk_cyc(0, 0, 0), 0, 3, 0, 0));
    // Kind 3 and width code 1: parameter write, 8-bit
    send(mk(3, 16'h9876, mk_onoff(0, 3, 1, 2, 0, 0), mk_cyc(3, 0, 0), 0, 1, 0, 0));
    // Back-to-back commands: the second is held while the first runs
    send(mk(0, 16'h0011, mk_onoff(0, 2, 0, 2, 0, 0), mk_cyc(3, 0, 0), 1, 3, 0, 0));
    send(mk(0, 16'h0022, mk_onoff(1, 3, 1, 2, 0, 0), mk_cyc(3, 0, 0), 0, 3, 0, 0));
    // Read whose result the consumer stalls
    send(mk(2, 0, mk_onoff(0, 3, 0, 0, 0, 2), mk_cyc(0, 3, 1), 0, 3, 16'h4440, 1));
    // A request offered behind the stalled result
    send(mk(1, 16'h5A5A, mk_onoff(0, 2, 0, 1, 0, 0), mk_cyc(2, 0, 0), 0, 3, 0, 0));

    while (q.size() != 0 || busy || rsp_valid) @(negedge clk);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule